// File: doc/BRIEF.md
# Operand Shifter and Immediate Expander

This block forms the second operand of an integer ALU and the carry bit that the shifter produces alongside it. In immediate mode it takes an 8-bit constant and rotates it right by twice a 4-bit rotate field, which gives a 32-bit operand. In register mode it takes a 32-bit register value and applies one of four shift kinds. The shift amount comes either from a 5-bit immediate field or from an 8-bit amount byte that the surrounding pipeline reads out of a second register. Some immediate amount values are reused: a zero field stands for a full-width shift, or for a one-bit rotate through the carry flag.

All the arithmetic is combinational. The result and the carry are captured in a single output register, so every answer appears one clock after its inputs. The block has no state machine. Its only state is the output register: one process computes the next value and a second one holds it, under an active-low reset that clears it. Decode, the ALU, flag writeback and address arithmetic all sit outside this block.

Top module: `opsh_top`

## Requirements
- R1: While `rst_n` is low, `operand_out` and `carry_out` are 0. Once out of reset, the outputs show the result of the inputs that were present at the previous rising clock edge.
- R2: When `imm_sel`=1, `operand_out` is `imm_byte` zero-extended to 32 bits and rotated right by 2×`imm_rot` places. The shift inputs have no effect in this mode.
- R3: When `imm_sel`=1 and `imm_rot`≠0, `carry_out` equals bit 31 of the result. When `imm_rot`=0, `carry_out` equals `carry_in`.
- R4: `shift_kind` is encoded as 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For an immediate amount n from 1 to 31, the value is shifted n places, and `carry_out` is the last bit shifted out (for rotate right, the new bit 31).
- R5: A logical left shift with immediate amount 0 passes the value through unchanged, and `carry_out` equals `carry_in`.
- R6: A logical right shift with immediate amount 0 acts as a 32-place shift. The result is 0 and `carry_out` is bit 31 of the input.
- R7: An arithmetic right shift with immediate amount 0 acts as a 32-place shift. Every result bit and `carry_out` equal bit 31 of the input.
- R8: A rotate right with immediate amount 0 rotates one place through the carry. The result is `{carry_in, src_val[31:1]}` and `carry_out` is `src_val[0]`.
- R9: When `amt_from_reg`=1, the whole 8-bit `amt_byte` is the amount. An amount of 0 passes the value through, with `carry_out` equal to `carry_in`, for every shift kind.
- R10: A register-amount logical shift (left or right) of 32 gives 0, with `carry_out` equal to bit 0 for a left shift and bit 31 for a right shift. An amount above 32 gives 0 with `carry_out` 0.
- R11: A register-amount arithmetic right shift of 32 or more fills the result with bit 31, and `carry_out` is bit 31.
- R12: A register-amount rotate right with a nonzero amount rotates by the amount modulo 32, and `carry_out` is the result's bit 31. A nonzero multiple of 32 therefore leaves the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| src_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_imm | input | 5 | Immediate shift amount field |
| amt_from_reg | input | 1 | 1 selects `amt_byte` as the amount |
| amt_byte | input | 8 | Low byte of the amount register |
| imm_sel | input | 1 | 1 selects the rotated-immediate operand |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotation = 2× field) |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
Both the operand and the carry are due exactly one rising edge after the inputs that produce them. The bench drives each input set on a falling edge and compares both outputs on the next falling edge. Because it samples only there, it never reads a value that is still changing, and it never reads one that has already been replaced by the next vector. The expected values come from a bench model that moves bits one place at a time. That is a different method from the design's single-step shifter, and the model also handles the reused zero-amount codes by its own rules.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/opsh_imm_rot.sv
// Expands a small constant into a full-width operand by an even right rotation.
module opsh_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] imm_res,
    output logic              imm_cout
);
    localparam int AMT_BITS = ROT_W + 1;

    logic [DATA_W-1:0]   ext;
    logic [2*DATA_W-1:0] dbl;
    logic [AMT_BITS-1:0] rot_amt;

    always_comb begin
        ext     = DATA_W'(imm_byte);
        rot_amt = {imm_rot, 1'b0};
        dbl     = {ext, ext} >> rot_amt;
        imm_res = dbl[DATA_W-1:0];
        // Zero rotation leaves the carry flag as it was.
        imm_cout = (imm_rot == '0) ? carry_in : imm_res[DATA_W-1];
    end
endmodule

// File: rtl/opsh_amt_decode.sv
// Turns the immediate or register amount into one effective amount plus an RRX flag.
module opsh_amt_decode
    import opsh_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AMT_W     = 5,
    parameter int REG_AMT_W = 8,
    parameter int EFF_W     = 8
) (
    input  shift_kind_e          kind,
    input  logic [AMT_W-1:0]     amt_imm,
    input  logic                 from_reg,
    input  logic [REG_AMT_W-1:0] amt_byte,
    output logic [EFF_W-1:0]     eff_amt,
    output logic                 rrx
);
    localparam logic [EFF_W-1:0] FULL = EFF_W'(DATA_W);

    always_comb begin
        eff_amt = '0;
        rrx     = 1'b0;
        if (from_reg) begin
            eff_amt = EFF_W'(amt_byte);
        end else if (amt_imm != '0) begin
            eff_amt = EFF_W'(amt_imm);
        end else begin
            // A zero immediate field is reused per shift kind.
            unique case (kind)
                SH_LSL: eff_amt = '0;
                SH_LSR: eff_amt = FULL;
                SH_ASR: eff_amt = FULL;
                SH_ROR: rrx     = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/opsh_barrel.sv
// Single-step shifter for all four kinds plus rotate-through-carry.
module opsh_barrel
    import opsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EFF_W  = 8
) (
    input  logic [DATA_W-1:0] val,
    input  shift_kind_e       kind,
    input  logic [EFF_W-1:0]  amt,
    input  logic              rrx,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int LOG_W = $clog2(DATA_W);
    localparam logic [EFF_W-1:0] FULL = EFF_W'(DATA_W);

    logic [DATA_W:0]        wide;
    logic signed [DATA_W:0] swide;
    logic [EFF_W-1:0]       lim;
    logic [LOG_W-1:0]       r;
    logic [2*DATA_W-1:0]    dbl;

    always_comb begin
        res   = val;
        cout  = carry_in;
        wide  = '0;
        swide = '0;
        lim   = '0;
        r     = '0;
        dbl   = '0;
        if (rrx) begin
            res  = {carry_in, val[DATA_W-1:1]};
            cout = val[0];
        end else if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    if (amt > FULL) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        wide = {1'b0, val} << amt;
                        res  = wide[DATA_W-1:0];
                        cout = wide[DATA_W];
                    end
                end
                SH_LSR: begin
                    if (amt > FULL) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        wide = {val, 1'b0} >> amt;
                        res  = wide[DATA_W:1];
                        cout = wide[0];
                    end
                end
                SH_ASR: begin
                    lim   = (amt > FULL) ? FULL : amt;
                    swide = $signed({val, 1'b0}) >>> lim;
                    res   = swide[DATA_W:1];
                    cout  = swide[0];
                end
                SH_ROR: begin
                    r    = amt[LOG_W-1:0];
                    dbl  = {val, val} >> r;
                    res  = dbl[DATA_W-1:0];
                    cout = res[DATA_W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/opsh_top.sv
module opsh_top
    import opsh_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AMT_W     = 5,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    src_val,
    input  logic [1:0]           shift_kind,
    input  logic [AMT_W-1:0]     amt_imm,
    input  logic                 amt_from_reg,
    input  logic [REG_AMT_W-1:0] amt_byte,
    input  logic                 imm_sel,
    input  logic [IMM_W-1:0]     imm_byte,
    input  logic [ROT_W-1:0]     imm_rot,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    operand_out,
    output logic                 carry_out
);
    localparam int EFF_W = (REG_AMT_W > AMT_W + 1) ? REG_AMT_W : AMT_W + 1;

    shift_kind_e         kind;
    logic [EFF_W-1:0]    eff_amt;
    logic                rrx;
    logic [DATA_W-1:0]   sh_res;
    logic                sh_cout;
    logic [DATA_W-1:0]   imm_res;
    logic                imm_cout;
    logic [DATA_W-1:0]   nxt_val;
    logic                nxt_carry;

    assign kind = shift_kind_e'(shift_kind);

    opsh_amt_decode #(
        .DATA_W(DATA_W), .AMT_W(AMT_W), .REG_AMT_W(REG_AMT_W), .EFF_W(EFF_W)
    ) u_dec (
        .kind(kind), .amt_imm(amt_imm), .from_reg(amt_from_reg),
        .amt_byte(amt_byte), .eff_amt(eff_amt), .rrx(rrx)
    );

    opsh_barrel #(.DATA_W(DATA_W), .EFF_W(EFF_W)) u_sh (
        .val(src_val), .kind(kind), .amt(eff_amt), .rrx(rrx),
        .carry_in(carry_in), .res(sh_res), .cout(sh_cout)
    );

    opsh_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
        .imm_byte(imm_byte), .imm_rot(imm_rot), .carry_in(carry_in),
        .imm_res(imm_res), .imm_cout(imm_cout)
    );

    // Next-value process.
    always_comb begin
        nxt_val   = imm_sel ? imm_res  : sh_res;
        nxt_carry = imm_sel ? imm_cout : sh_cout;
    end

    // Output register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            operand_out <= '0;
            carry_out   <= 1'b0;
        end else begin
            operand_out <= nxt_val;
            carry_out   <= nxt_carry;
        end
    end

    // R2
    imm_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(imm_sel)) |->
            ($countones(operand_out) == $countones($past(imm_byte))));

    // R3
    imm_zero_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(imm_sel) && $past(imm_rot) == '0) |->
            (operand_out == DATA_W'($past(imm_byte)) && carry_out == $past(carry_in)));

    // R6
    lsr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && !$past(amt_from_reg) &&
         $past(shift_kind) == 2'b01 && $past(amt_imm) == '0) |->
            (operand_out == '0 && carry_out == $past(src_val[DATA_W-1])));

    // R7
    asr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && !$past(amt_from_reg) &&
         $past(shift_kind) == 2'b10 && $past(amt_imm) == '0) |->
            (operand_out == {DATA_W{$past(src_val[DATA_W-1])}} &&
             carry_out == $past(src_val[DATA_W-1])));

    // R8
    rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && !$past(amt_from_reg) &&
         $past(shift_kind) == 2'b11 && $past(amt_imm) == '0) |->
            (operand_out == {$past(carry_in), $past(src_val[DATA_W-1:1])} &&
             carry_out == $past(src_val[0])));

    // R9
    reg_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && $past(amt_from_reg) && $past(amt_byte) == '0) |->
            (operand_out == $past(src_val) && carry_out == $past(carry_in)));

    // R10
    reg_logic_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(imm_sel) && $past(amt_from_reg) &&
         !$past(shift_kind[1]) && $past(amt_byte) > REG_AMT_W'(DATA_W)) |->
            (operand_out == '0 && carry_out == 1'b0));
endmodule

// File: tb/opsh_top_tb.sv
`timescale 1ns/1ps
module opsh_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_val = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  amt_imm = '0;
    logic        amt_from_reg = 1'b0;
    logic [7:0]  amt_byte = '0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    opsh_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_val(src_val), .shift_kind(shift_kind),
        .amt_imm(amt_imm), .amt_from_reg(amt_from_reg), .amt_byte(amt_byte),
        .imm_sel(imm_sel), .imm_byte(imm_byte), .imm_rot(imm_rot),
        .carry_in(carry_in), .operand_out(operand_out), .carry_out(carry_out)
    );

    // Bit-at-a-time reference model; returns {carry, value}.
    function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] k,
            input logic [4:0] ai, input logic fr, input logic [7:0] ab,
            input logic is, input logic [7:0] b, input logic [3:0] rt, input logic c);
        logic [31:0] x;
        logic        cy;
        int          n;
        cy = c;
        if (is) begin
            x = {24'b0, b};
            for (int i = 0; i < 2 * rt; i++) x = {x[0], x[31:1]};
            if (rt != 0) cy = x[31];
            return {cy, x};
        end
        x = v;
        if (fr) n = ab;
        else begin
            n = ai;
            if (ai == 0) begin
                if (k == 2'b01 || k == 2'b10) n = 32;
                if (k == 2'b11) return {v[0], c, v[31:1]};
            end
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin cy = x[31]; x = {x[30:0], 1'b0}; end
                2'b01: begin cy = x[0];  x = {1'b0, x[31:1]}; end
                2'b10: begin cy = x[0];  x = {x[31], x[31:1]}; end
                default: begin cy = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {cy, x};
    endfunction

    function automatic string tag_of(input logic [1:0] k, input logic [4:0] ai,
            input logic fr, input logic [7:0] ab, input logic is);
        if (is) return "R2/R3";
        if (fr) begin
            if (ab == 0) return "R9";
            if (k == 2'b10 && ab >= 32) return "R11";
            if (k == 2'b11) return "R12";
            if (ab >= 32) return "R10";
            return "R4";
        end
        if (ai == 0) begin
            case (k)
                2'b00: return "R5";
                2'b01: return "R6";
                2'b10: return "R7";
                default: return "R8";
            endcase
        end
        return "R4";
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic apply(input logic [31:0] v, input logic [1:0] k, input logic [4:0] ai,
            input logic fr, input logic [7:0] ab, input logic is, input logic [7:0] b,
            input logic [3:0] rt, input logic c);
        logic [32:0] exp;
        string       tg;
        @(negedge clk);
        src_val = v; shift_kind = k; amt_imm = ai; amt_from_reg = fr; amt_byte = ab;
        imm_sel = is; imm_byte = b; imm_rot = rt; carry_in = c;
        exp = model(v, k, ai, fr, ab, is, b, rt, c);
        tg  = tag_of(k, ai, fr, ab, is);
        @(negedge clk);
        checks++;
        if ({carry_out, operand_out} !== exp) begin
            fails++;
            $display("FAIL %s: actual c=%0b v=%08h expected c=%0b v=%08h",
                     tg, carry_out, operand_out, exp[32], exp[31:0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: outputs held at zero in reset even with busy inputs
        src_val = 32'hFFFF_FFFF; imm_sel = 1'b1; imm_byte = 8'hFF; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (operand_out !== '0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual c=%0b v=%08h expected c=0 v=00000000", carry_out, operand_out);
        end
        rst_n = 1'b1;

        // R1: one-cycle latency, next vector visible after one edge
        apply(32'h8000_0001, 2'b00, 5'd1, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        // R2 / R3 immediates
        apply(32'h0, 2'b00, 5'd0, 1'b0, 8'd0, 1'b1, 8'hA5, 4'd0, 1'b1);
        apply(32'h0, 2'b00, 5'd0, 1'b0, 8'd0, 1'b1, 8'hFF, 4'd4, 1'b0);
        apply(32'h0, 2'b00, 5'd0, 1'b0, 8'd0, 1'b1, 8'h03, 4'd1, 1'b0);
        apply(32'hDEAD_BEEF, 2'b11, 5'd0, 1'b1, 8'd3, 1'b1, 8'h40, 4'd15, 1'b1);
        // R4 normal immediate shifts
        apply(32'h8000_0001, 2'b00, 5'd1, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h8000_0001, 2'b01, 5'd31, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h8000_0000, 2'b10, 5'd4, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h0000_00F1, 2'b11, 5'd4, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        // R5..R8 zero immediate field
        apply(32'h1234_5678, 2'b00, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b1);
        apply(32'h8765_4321, 2'b01, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h8765_4321, 2'b10, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h7000_0000, 2'b10, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b1);
        apply(32'h0000_0003, 2'b11, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b1);
        apply(32'h0000_0002, 2'b11, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 4'd0, 1'b0);
        // R9 register amount zero
        for (int k = 0; k < 4; k++)
            apply(32'hCAFE_F00D, 2'(k), 5'd7, 1'b1, 8'd0, 1'b0, 8'd0, 4'd0, 1'b1);
        // R10 register logical at and beyond 32
        apply(32'h0000_0001, 2'b00, 5'd0, 1'b1, 8'd32, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h8000_0000, 2'b01, 5'd0, 1'b1, 8'd32, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'hFFFF_FFFF, 2'b00, 5'd0, 1'b1, 8'd33, 1'b0, 8'd0, 4'd0, 1'b1);
        apply(32'hFFFF_FFFF, 2'b01, 5'd0, 1'b1, 8'd255, 1'b0, 8'd0, 4'd0, 1'b1);
        // R11 register arithmetic beyond width
        apply(32'h8000_0000, 2'b10, 5'd0, 1'b1, 8'd200, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h7FFF_FFFF, 2'b10, 5'd0, 1'b1, 8'd32, 1'b0, 8'd0, 4'd0, 1'b1);
        // R12 register rotate
        apply(32'h8000_0001, 2'b11, 5'd0, 1'b1, 8'd32, 1'b0, 8'd0, 4'd0, 1'b0);
        apply(32'h0000_0001, 2'b11, 5'd0, 1'b1, 8'd64, 1'b0, 8'd0, 4'd0, 1'b1);
        apply(32'h0000_0010, 2'b11, 5'd0, 1'b1, 8'd37, 1'b0, 8'd0, 4'd0, 1'b0);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ab;
            logic [4:0] ai;
            ab = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 40);
            ai = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            apply($urandom, 2'($urandom), ai, 1'($urandom), ab,
                  ($urandom % 4 == 0), 8'($urandom), 4'($urandom), 1'($urandom));
        end

        done = 1'b1;
        report();
    end
endmodule